// File: doc/BRIEF.md
# Divergence-Masked Cache Line Segment Gating

This block sits in front of a cache data array and decides which segments of a line take part in each access. In a SIMT machine, a warp of threads shares one instruction stream. When the threads take a branch in different directions, the warp runs the branch in two phases. The threads that took the branch run first, and then the threads that fell through run. While one group runs, the lanes of the other group are idle. The block gives each lane its own slice of the cache line and enables only the slices that belong to lanes active in the current phase. The data array therefore drives or stores no bits for idle lanes.

The block has a small state machine with three states:

- `PH_JOINED`: no divergence. The live warp mask selects the lanes.
- `PH_TAKEN`: first phase. The taken-path lanes are active.
- `PH_FALLTHRU`: second phase. The lanes that were active before the branch but did not take it are active.

The transitions are:

- `JOINED->TAKEN`: a divergence with at least one taken lane.
- `JOINED->FALLTHRU`: a divergence with no taken lane, so the empty first phase is skipped.
- `TAKEN->FALLTHRU`: a phase-done signal while some lanes did not take the branch.
- `TAKEN->JOINED`: a phase-done signal when no lane fell through, so the empty second phase is skipped.
- `FALLTHRU->JOINED`: a phase-done signal.

The segment enables are registered and reach the data array one cycle after the request is presented.

Top module: `dm_lane_gate`

## Requirements
- R1: After reset, `phase_state` is 2'b00 (joined), `seg_en` is all zero and `line_access` is 0.
- R2: In the joined state (`phase_state` 2'b00), `phase_mask` equals the live `warp_mask`. A request with `req_valid` high in cycle t gives `seg_en` equal to the expansion of that mask in cycle t+1.
- R3: With `req_valid` low in cycle t, `seg_en` is all zero and `line_access` is 0 in cycle t+1.
- R4: If `diverge` is high in the joined state, the next cycle is in the taken state (2'b01), with `phase_mask` = `taken_mask & warp_mask` as captured on the divergence cycle. The request presented on the divergence cycle still uses the joined mask.
- R5: If `phase_done` is high in the taken state, the next cycle is in the fall-through state (2'b10), with `phase_mask` = captured warp mask AND NOT captured taken mask. This mask shares no lane with the taken-phase mask.
- R6: If `phase_done` is high in the fall-through state, the next cycle is in the joined state, and `phase_mask` follows the live `warp_mask` again.
- R7: A phase whose active mask would be all zero is skipped. With no taken lane, a divergence goes straight to the fall-through state. With no fall-through lane, `phase_done` in the taken state returns to joined. With an all-zero captured warp mask, the block stays joined. The taken and fall-through states therefore always have a nonzero `phase_mask`.
- R8: A request whose phase mask is all zero causes no cache access. In the next cycle `seg_en` is all zero and `line_access` is 0.
- R9: While divergent, `diverge` and changes on `warp_mask` and `taken_mask` have no effect on `phase_state` or `phase_mask`. While joined, `phase_done` has no effect.
- R10: There are SEG_PER_LANE segments per lane (default 2, with 32 lanes, giving 64 segments). Segment j belongs to lane j / SEG_PER_LANE, and it is enabled only when that lane is active in the phase mask of the request. `line_access` is 1 exactly when a request had a nonzero mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cache access request this cycle |
| warp_mask | input | LANES | Active-thread mask of the warp |
| diverge | input | 1 | Branch diverges this cycle; captures masks when joined |
| taken_mask | input | LANES | Lanes whose threads take the branch |
| phase_done | input | 1 | Current divergence phase has finished |
| seg_en | output | LANES*SEG_PER_LANE | Registered per-segment enables for the data array |
| line_access | output | 1 | Registered: an access with at least one segment enabled |
| phase_mask | output | LANES | Active lane mask of the current phase |
| phase_state | output | 2 | 00 joined, 01 taken phase, 10 fall-through phase |

## Verification
The following properties are checked on every cycle:

- The state encoding is legal.
- Every enabled segment belongs to a lane of the previous cycle's phase mask.
- An idle cycle or an empty mask never becomes an access.
- A divergent state always has a nonempty mask.
- The two phase masks are disjoint.
- The state and mask hold while a phase has not finished.

Some behaviour can only be shown by the bench scenarios, because it needs the exact mask values:

- The exact masks captured at a divergence.
- Which skip path is taken for empty phases.
- That requests on the divergence cycle use the joined mask.
- That nested divergences and joined-state phase-done pulses leave everything unchanged.

// File: rtl/dm_pkg.sv
package dm_pkg;

    typedef enum logic [1:0] {
        PH_JOINED   = 2'b00,
        PH_TAKEN    = 2'b01,
        PH_FALLTHRU = 2'b10
    } phase_e;

endpackage

// File: rtl/dm_phase_fsm.sv
module dm_phase_fsm
    import dm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   diverge,
    input  logic   phase_done,
    input  logic   entry_taken_any,
    input  logic   entry_fall_any,
    input  logic   held_fall_any,
    output phase_e state
);

    phase_e state_q;
    phase_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_JOINED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic; empty phases are skipped (R7)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_JOINED: begin
                if (diverge) begin
                    if (entry_taken_any) begin
                        state_d = PH_TAKEN;
                    end else if (entry_fall_any) begin
                        state_d = PH_FALLTHRU;
                    end else begin
                        state_d = PH_JOINED;
                    end
                end
            end
            PH_TAKEN: begin
                if (phase_done) begin
                    state_d = held_fall_any ? PH_FALLTHRU : PH_JOINED;
                end
            end
            PH_FALLTHRU: begin
                if (phase_done) begin
                    state_d = PH_JOINED;
                end
            end
            default: state_d = PH_JOINED;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/dm_mask_store.sv
module dm_mask_store
    import dm_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           state,
    input  logic             diverge,
    input  logic [LANES-1:0] warp_mask,
    input  logic [LANES-1:0] taken_mask,
    output logic [LANES-1:0] phase_mask,
    output logic             entry_taken_any,
    output logic             entry_fall_any,
    output logic             held_fall_any
);

    logic [LANES-1:0] base_q;
    logic [LANES-1:0] taken_q;
    logic [LANES-1:0] new_taken;
    logic [LANES-1:0] new_fall;
    logic [LANES-1:0] held_fall;
    logic             capture;

    assign new_taken = taken_mask & warp_mask;
    assign new_fall  = warp_mask & ~taken_mask;
    assign held_fall = base_q & ~taken_q;
    assign capture   = (state == PH_JOINED) && diverge;

    // Masks are captured only on a divergence in the joined state (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            taken_q <= '0;
        end else if (capture) begin
            base_q  <= warp_mask;
            taken_q <= new_taken;
        end
    end

    assign entry_taken_any = |new_taken;
    assign entry_fall_any  = |new_fall;
    assign held_fall_any   = |held_fall;

    // Phase mask selection (R2, R4, R5)
    always_comb begin
        unique case (state)
            PH_JOINED:   phase_mask = warp_mask;
            PH_TAKEN:    phase_mask = taken_q;
            PH_FALLTHRU: phase_mask = held_fall;
            default:     phase_mask = '0;
        endcase
    end

endmodule

// File: rtl/dm_seg_drive.sv
module dm_seg_drive #(
    parameter int LANES        = 32,
    parameter int SEG_PER_LANE = 2,
    localparam int SEGS        = LANES * SEG_PER_LANE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LANES-1:0] phase_mask,
    output logic [SEGS-1:0]  seg_en,
    output logic             line_access
);

    logic [SEGS-1:0] seg_d;
    logic            access_d;

    // Segment j belongs to lane j / SEG_PER_LANE (R10)
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        for (genvar sb = 0; sb < SEG_PER_LANE; sb++) begin : g_sub
            assign seg_d[ln*SEG_PER_LANE + sb] = req_valid & phase_mask[ln];
        end
    end

    // An empty mask makes no access (R8)
    assign access_d = req_valid & (|phase_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_en      <= '0;
            line_access <= 1'b0;
        end else begin
            seg_en      <= seg_d;
            line_access <= access_d;
        end
    end

endmodule

// File: rtl/dm_lane_gate.sv
module dm_lane_gate
    import dm_pkg::*;
#(
    parameter int LANES        = 32,
    parameter int SEG_PER_LANE = 2,
    localparam int SEGS        = LANES * SEG_PER_LANE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LANES-1:0] warp_mask,
    input  logic             diverge,
    input  logic [LANES-1:0] taken_mask,
    input  logic             phase_done,
    output logic [SEGS-1:0]  seg_en,
    output logic             line_access,
    output logic [LANES-1:0] phase_mask,
    output logic [1:0]       phase_state
);

    phase_e state;
    logic   entry_taken_any;
    logic   entry_fall_any;
    logic   held_fall_any;

    dm_phase_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .diverge         (diverge),
        .phase_done      (phase_done),
        .entry_taken_any (entry_taken_any),
        .entry_fall_any  (entry_fall_any),
        .held_fall_any   (held_fall_any),
        .state           (state)
    );

    dm_mask_store #(.LANES(LANES)) u_masks (
        .clk             (clk),
        .rst_n           (rst_n),
        .state           (state),
        .diverge         (diverge),
        .warp_mask       (warp_mask),
        .taken_mask      (taken_mask),
        .phase_mask      (phase_mask),
        .entry_taken_any (entry_taken_any),
        .entry_fall_any  (entry_fall_any),
        .held_fall_any   (held_fall_any)
    );

    dm_seg_drive #(.LANES(LANES), .SEG_PER_LANE(SEG_PER_LANE)) u_seg (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .phase_mask  (phase_mask),
        .seg_en      (seg_en),
        .line_access (line_access)
    );

    assign phase_state = state;

endmodule

// File: rtl/dm_lane_gate_chk.sv
module dm_lane_gate_chk #(
    parameter int LANES        = 32,
    parameter int SEG_PER_LANE = 2,
    localparam int SEGS        = LANES * SEG_PER_LANE
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             phase_done,
    input logic [SEGS-1:0]  seg_en,
    input logic             line_access,
    input logic [LANES-1:0] phase_mask,
    input logic [1:0]       phase_state
);

    logic             armed_q;
    logic             req_q;
    logic [LANES-1:0] mask_q;
    logic [SEGS-1:0]  allowed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            req_q   <= 1'b0;
            mask_q  <= '0;
        end else begin
            armed_q <= 1'b1;
            req_q   <= req_valid;
            mask_q  <= phase_mask;
        end
    end

    for (genvar j = 0; j < SEGS; j++) begin : g_allow
        assign allowed[j] = mask_q[j / SEG_PER_LANE];
    end

    p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_state != 2'b11);

    p_quiet_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !req_q) |-> (seg_en == '0 && !line_access));

    p_seg_within_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((seg_en & ~allowed) == '0));

    p_access_has_segments_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_access |-> (seg_en != '0));

    p_empty_mask_no_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && mask_q == '0) |-> !line_access);

    p_divergent_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_state != 2'b00) |-> (phase_mask != '0));

    p_phases_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_state == 2'b01 && phase_done) |=>
            (phase_state != 2'b10 || (phase_mask & $past(phase_mask)) == '0));

    p_fallthru_rejoins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_state == 2'b10 && phase_done) |=> (phase_state == 2'b00));

    p_hold_in_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_state != 2'b00 && !phase_done) |=>
            ($stable(phase_state) && $stable(phase_mask)));

endmodule

bind dm_lane_gate dm_lane_gate_chk #(
    .LANES        (LANES),
    .SEG_PER_LANE (SEG_PER_LANE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .phase_done  (phase_done),
    .seg_en      (seg_en),
    .line_access (line_access),
    .phase_mask  (phase_mask),
    .phase_state (phase_state)
);

// File: tb/sim_dm_lane_gate.sv
`timescale 1ns/1ps
module sim_dm_lane_gate;

    localparam int LANES = 32;
    localparam int SPL   = 2;
    localparam int SEGS  = LANES * SPL;

    logic             clk;
    logic             rst_n;
    logic             req_valid;
    logic [LANES-1:0] warp_mask;
    logic             diverge;
    logic [LANES-1:0] taken_mask;
    logic             phase_done;
    logic [SEGS-1:0]  seg_en;
    logic             line_access;
    logic [LANES-1:0] phase_mask;
    logic [1:0]       phase_state;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    int               m_state = 0;
    logic [LANES-1:0] m_base  = '0;
    logic [LANES-1:0] m_taken = '0;

    dm_lane_gate #(.LANES(LANES), .SEG_PER_LANE(SPL)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .warp_mask   (warp_mask),
        .diverge     (diverge),
        .taken_mask  (taken_mask),
        .phase_done  (phase_done),
        .seg_en      (seg_en),
        .line_access (line_access),
        .phase_mask  (phase_mask),
        .phase_state (phase_state)
    );

    initial clk = 0;
    always #4 clk = ~clk;

    function automatic logic [SEGS-1:0] expand(input logic [LANES-1:0] m);
        logic [SEGS-1:0] r;
        for (int j = 0; j < SEGS; j++) r[j] = m[j / SPL];
        return r;
    endfunction

    function automatic logic [LANES-1:0] model_mask(input logic [LANES-1:0] w);
        if (m_state == 1) return m_taken;
        if (m_state == 2) return m_base & ~m_taken;
        return w;
    endfunction

    task automatic check(input logic [127:0] act, input logic [127:0] exp,
                         input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [LANES-1:0] w, input logic [LANES-1:0] t,
                        input logic r, input logic d, input logic p, input string tag);
        logic [LANES-1:0] em;
        logic [SEGS-1:0]  es;
        logic             ea;
        logic [LANES-1:0] nt;
        logic [LANES-1:0] nf;
        req_valid  = r;
        warp_mask  = w;
        taken_mask = t;
        diverge    = d;
        phase_done = p;
        #1;
        em = model_mask(w);
        check(128'(phase_state), 128'(m_state), tag, "phase_state");
        check(128'(phase_mask), 128'(em), tag, "phase_mask");
        es = r ? expand(em) : '0;
        ea = r && (em != '0);
        if (m_state == 0) begin
            if (d) begin
                nt = t & w;
                nf = w & ~t;
                m_base  = w;
                m_taken = nt;
                if (nt != '0) m_state = 1;
                else if (nf != '0) m_state = 2;
            end
        end else if (m_state == 1) begin
            if (p) m_state = ((m_base & ~m_taken) != '0) ? 2 : 0;
        end else begin
            if (p) m_state = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check(128'(seg_en), 128'(es), tag, "seg_en");
        check(128'(line_access), 128'(ea), tag, "line_access");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [LANES-1:0] rw;
        logic [LANES-1:0] rt;
        string            tg;
        void'($urandom(32'd1234));
        rst_n = 0; req_valid = 0; warp_mask = '0; diverge = 0;
        taken_mask = '0; phase_done = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(128'(phase_state), 128'(0), "R1", "phase_state");
        check(128'(seg_en), 128'(0), "R1", "seg_en");
        check(128'(line_access), 128'(0), "R1", "line_access");
        rst_n = 1;

        step(32'h0000_0001, '0, 1, 0, 0, "R10");
        step(32'hFFFF_0000, '0, 1, 0, 0, "R2");
        step(32'h0000_FFFF, '0, 0, 0, 0, "R3");
        step(32'h0000_0000, '0, 1, 0, 0, "R8");
        step(32'h0F0F_0F0F, '0, 1, 0, 1, "R9");
        step(32'h00FF_00FF, 32'h0000_FFFF, 1, 1, 0, "R4");
        step(32'h1234_5678, 32'hFFFF_FFFF, 1, 1, 0, "R9");
        step(32'hFFFF_FFFF, 32'h0000_0000, 1, 0, 1, "R5");
        step(32'h0000_0001, 32'h0000_0000, 1, 0, 0, "R5");
        step(32'h0000_0001, 32'h0000_0000, 0, 0, 1, "R6");
        step(32'hAAAA_AAAA, 32'h0000_0000, 1, 0, 0, "R6");
        step(32'h0000_00F0, 32'h0000_000F, 1, 1, 0, "R7");
        step(32'h0000_00F0, 32'h0000_000F, 1, 0, 1, "R7");
        step(32'h0000_00F0, 32'h0000_00FF, 1, 1, 0, "R7");
        step(32'h0000_00F0, 32'h0000_00FF, 1, 0, 1, "R7");
        step(32'h0000_0000, 32'h0000_00FF, 1, 1, 0, "R7");
        step(32'h0000_0001, 32'h0000_0000, 1, 0, 0, "R7");

        for (int i = 0; i < 4000; i++) begin
            rw = $urandom;
            rt = $urandom;
            if ($urandom_range(15) == 0) rw = '0;
            if ($urandom_range(7) == 0) rt = '0;
            if ($urandom_range(7) == 0) rt = '1;
            tg = (m_state == 0) ? "R2" : ((m_state == 1) ? "R4" : "R5");
            step(rw, rt, ($urandom_range(3) != 0), ($urandom_range(7) == 0),
                 ($urandom_range(5) == 0), tg);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule